// File: doc/BRIEF.md
# Six-Mode Mantissa Rounding Stage

This block performs the rounding step for a single-precision multiply or similar datapath. It takes a normalized 24-bit significand (leading one plus 23 fraction bits), the guard and sticky bits that were dropped below it, the sign of the result and a 3-bit policy code. It decides whether the significand must be bumped by one unit in the last place. It returns the result in a 25-bit field, so a carry that ripples out of an all-ones significand is kept for a later stage. It also raises an inexact indication whenever any discarded bit was set.

The decision logic is combinational. The outputs are captured in a register stage with a synchronous active-high reset, so results appear one clock after the inputs are presented. Later stages handle renormalizing after a carry, adjusting the exponent and handling special operands.

Top module: `rnd_unit`

## Requirements
- R1: With mode code 0 (nearest, ties to even), the significand is incremented exactly when guard is 1 and at least one of sticky and the significand LSB (bit 0) is 1.
- R2: With mode code 1 (toward zero), the output is always the input significand zero-extended to 25 bits; no increment ever happens.
- R3: With mode code 2 (toward plus infinity), the significand is incremented exactly when sign is 0 and guard or sticky is 1.
- R4: With mode code 3 (toward minus infinity), the significand is incremented exactly when sign is 1 and guard or sticky is 1.
- R5: With mode code 4 (nearest, ties away by magnitude), the significand is incremented exactly when guard is 1.
- R6: With mode code 5 (away from zero), the significand is incremented exactly when guard or sticky is 1.
- R7: Mode codes 6 and 7 give the same result as mode code 0.
- R8: The output is 25 bits wide with the carry in bit 24. Incrementing 0xFFFFFF gives 0x1000000. Whenever bit 24 is 1, bits 23..0 are 0.
- R9: The inexact output equals guard OR sticky in every mode.
- R10: The outputs are registered. Inputs present at a rising edge appear on the outputs after that edge. A rising edge with reset high clears the significand output and the inexact output to 0.
- R11: When guard and sticky are both 0, the output equals the zero-extended input in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mant_i | input | 24 | Normalized significand, leading one included |
| guard_i | input | 1 | First discarded bit below the LSB |
| sticky_i | input | 1 | OR of all lower discarded bits |
| sign_i | input | 1 | Result sign, 1 = negative |
| mode_i | input | 3 | Rounding policy code (0..5, 6 and 7 alias 0) |
| mant_o | output | 25 | Rounded significand, bit 24 holds the carry |
| inexact_o | output | 1 | Set when guard or sticky was set |

## Verification
The bench targets the exact tie (guard set, sticky clear) with the LSB both even and odd. A design that confuses ties-to-even with ties-up rounds an even tie upward. The directed modes are exercised with both signs, where a swapped sign test would bump negative values in the plus-infinity mode. Mode codes 6 and 7 are driven on an odd tie to catch a design that leaves them truncating. The all-ones significand is rounded up to show whether the carry lands in bit 24 or is lost by a 24-bit adder. A mid-run reset checks that stale results are cleared.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_TO_ZERO   = 3'd1,
    RM_TO_POS    = 3'd2,
    RM_TO_NEG    = 3'd3,
    RM_NEAR_UP   = 3'd4,
    RM_AWAY      = 3'd5
  } rmode_e;

  localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic              lsb_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              inc_o,
  output logic              inexact_o
);
  logic lost;
  logic near_even;

  assign lost      = guard_i | sticky_i;
  assign near_even = guard_i & (sticky_i | lsb_i);

  always_comb begin
    case (mode_i)
      RM_NEAR_EVEN: inc_o = near_even;
      RM_TO_ZERO:   inc_o = 1'b0;
      RM_TO_POS:    inc_o = ~sign_i & lost;
      RM_TO_NEG:    inc_o = sign_i & lost;
      RM_NEAR_UP:   inc_o = guard_i;
      RM_AWAY:      inc_o = lost;
      default:      inc_o = near_even;
    endcase
  end

  assign inexact_o = lost;
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int unsigned W        = 24,
  parameter bit          RIPPLE   = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic         inc_i,
  output logic [W:0]   sum_o
);
  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0] carry;
      assign carry[0] = inc_i;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]     = a_i[i] ^ carry[i];
        assign carry[i+1]   = a_i[i] & carry[i];
      end
      assign sum_o[W] = carry[W];
    end else begin : g_behav
      assign sum_o = {1'b0, a_i} + {{W{1'b0}}, inc_i};
    end
  endgenerate
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int unsigned MANT_W = 24,
  parameter bit          RIPPLE = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [MANT_W-1:0]   mant_i,
  input  logic                guard_i,
  input  logic                sticky_i,
  input  logic                sign_i,
  input  logic [MODE_W-1:0]   mode_i,
  output logic [MANT_W:0]     mant_o,
  output logic                inexact_o
);
  localparam int unsigned OUT_W = MANT_W + 1;

  logic             inc;
  logic             inexact_d;
  logic [OUT_W-1:0] sum_d;

  rnd_decide u_decide (
    .lsb_i     (mant_i[0]),
    .guard_i   (guard_i),
    .sticky_i  (sticky_i),
    .sign_i    (sign_i),
    .mode_i    (mode_i),
    .inc_o     (inc),
    .inexact_o (inexact_d)
  );

  rnd_incr #(.W(MANT_W), .RIPPLE(RIPPLE)) u_incr (
    .a_i   (mant_i),
    .inc_i (inc),
    .sum_o (sum_d)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mant_o    <= '0;
      inexact_o <= 1'b0;
    end else begin
      mant_o    <= sum_d;
      inexact_o <= inexact_d;
    end
  end
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk
  import rnd_pkg::*;
#(
  parameter int unsigned MANT_W = 24
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic [MANT_W-1:0]   mant_i,
  input logic                guard_i,
  input logic                sticky_i,
  input logic                sign_i,
  input logic [MODE_W-1:0]   mode_i,
  input logic [MANT_W:0]     mant_o,
  input logic                inexact_o
);
  logic seen_rst;
  logic live;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seen_rst <= 1'b1;
      live     <= 1'b0;
    end else begin
      live     <= seen_rst;
    end
  end

  AST_TRUNC_NO_INC: assert property (@(posedge clk_i) disable iff (rst_i)
    live && $past(mode_i) == 3'd1 |-> mant_o == {1'b0, $past(mant_i)}); // R2

  AST_POS_NEG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    live && $past(mode_i) == 3'd2 && $past(sign_i) |-> mant_o == {1'b0, $past(mant_i)}); // R3

  AST_NEG_POS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    live && $past(mode_i) == 3'd3 && !$past(sign_i) |-> mant_o == {1'b0, $past(mant_i)}); // R4

  AST_CARRY_CLEAN: assert property (@(posedge clk_i) disable iff (rst_i)
    live && mant_o[MANT_W] |-> mant_o[MANT_W-1:0] == '0); // R8

  AST_INEXACT_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    live |-> inexact_o == ($past(guard_i) | $past(sticky_i))); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    seen_rst && $past(rst_i) |-> mant_o == '0 && !inexact_o); // R10

  AST_EXACT_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
    live && !$past(guard_i) && !$past(sticky_i) |-> mant_o == {1'b0, $past(mant_i)}); // R11
endmodule

bind rnd_unit rnd_unit_chk #(.MANT_W(MANT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .mant_i    (mant_i),
  .guard_i   (guard_i),
  .sticky_i  (sticky_i),
  .sign_i    (sign_i),
  .mode_i    (mode_i),
  .mant_o    (mant_o),
  .inexact_o (inexact_o)
);

// File: tb/sim_rnd_unit.sv
module sim_rnd_unit;
  localparam int CLK_P = 10;
  localparam int MW    = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic [MW-1:0] mant;
  logic          g, s, sg;
  logic [2:0]    mode;
  logic [MW:0]   mant_o;
  logic          inexact_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rnd_unit u0 (
    .clk_i(clk), .rst_i(rst), .mant_i(mant), .guard_i(g), .sticky_i(s),
    .sign_i(sg), .mode_i(mode), .mant_o(mant_o), .inexact_o(inexact_o)
  );

  function automatic logic ref_inc(input logic [MW-1:0] m, input logic gg,
                                   input logic ss, input logic sn, input logic [2:0] md);
    logic any;
    any = gg | ss;
    case (md)
      3'd1: return 1'b0;                  // R2
      3'd2: return !sn && any;            // R3
      3'd3: return sn && any;             // R4
      3'd4: return gg;                    // R5
      3'd5: return any;                   // R6
      default: return gg && (ss || m[0]); // R1, R7
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [MW:0] act, input logic [MW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [MW-1:0] m, input logic gg,
                       input logic ss, input logic sn, input logic [2:0] md);
    logic [MW:0] exp;
    @(negedge clk);
    mant = m; g = gg; s = ss; sg = sn; mode = md;
    @(posedge clk);
    #1;
    exp = {1'b0, m} + {{MW{1'b0}}, ref_inc(m, gg, ss, sn, md)};
    cmp(tag, mant_o, exp);
    cmp({tag, " R9 inexact"}, {{MW{1'b0}}, inexact_o}, {{MW{1'b0}}, gg | ss});
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    cmp("R10 reset mant", mant_o, '0);
    cmp("R10 reset inexact", {{MW{1'b0}}, inexact_o}, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_near_even;
    apply("R1 even tie", 24'h800002, 1, 0, 0, 3'd0);
    apply("R1 odd tie", 24'h800003, 1, 0, 0, 3'd0);
    apply("R1 above half", 24'h800002, 1, 1, 1, 3'd0);
    apply("R1 below half", 24'h800003, 0, 1, 0, 3'd0);
  endtask

  task automatic t_trunc;
    apply("R2 full lost", 24'hABCDEF, 1, 1, 0, 3'd1);
    apply("R2 neg lost", 24'hFFFFFF, 1, 1, 1, 3'd1);
  endtask

  task automatic t_to_pos;
    apply("R3 pos sticky", 24'h900000, 0, 1, 0, 3'd2);
    apply("R3 neg guard", 24'h900000, 1, 0, 1, 3'd2);
  endtask

  task automatic t_to_neg;
    apply("R4 neg sticky", 24'hC00001, 0, 1, 1, 3'd3);
    apply("R4 pos guard", 24'hC00001, 1, 1, 0, 3'd3);
  endtask

  task automatic t_near_up;
    apply("R5 even tie", 24'h800002, 1, 0, 1, 3'd4);
    apply("R5 sticky only", 24'h800002, 0, 1, 0, 3'd4);
  endtask

  task automatic t_away;
    apply("R6 sticky only", 24'h800004, 0, 1, 1, 3'd5);
    apply("R6 guard pos", 24'h800004, 1, 0, 0, 3'd5);
  endtask

  task automatic t_alias;
    apply("R7 code6 odd tie", 24'h800001, 1, 0, 0, 3'd6);
    apply("R7 code7 odd tie", 24'h800001, 1, 0, 1, 3'd7);
    apply("R7 code7 even tie", 24'h800000, 1, 0, 0, 3'd7);
  endtask

  task automatic t_carry;
    apply("R8 carry out", 24'hFFFFFF, 1, 1, 0, 3'd5);
    cmp("R8 carry bit", {{MW{1'b0}}, mant_o[MW]}, {{MW{1'b0}}, 1'b1});
    apply("R8 carry near even", 24'hFFFFFF, 1, 0, 0, 3'd0);
  endtask

  task automatic t_exact;
    for (int md = 0; md < 8; md++)
      apply("R11 exact", 24'hA5A5A5, 0, 0, md[0], md[2:0]);
  endtask

  initial begin
    rst = 1'b1; mant = '0; g = 0; s = 0; sg = 0; mode = '0;
    repeat (2) @(posedge clk);
    t_reset;
    t_near_even;
    t_trunc;
    t_to_pos;
    t_to_neg;
    t_near_up;
    t_away;
    t_alias;
    t_carry;
    t_exact;
    apply("R10 before reset", 24'hFFFFFF, 1, 1, 0, 3'd5);
    t_reset;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule